// File: doc/BRIEF.md
# Serial EEPROM Slave Read Engine

This block is the read side of a byte-addressed two-wire serial EEPROM slave. It watches the clock and data lines of an I2C bus, which it oversamples with the system clock. It finds start and stop conditions and decodes the device select byte. When the select byte asks for a read, it shifts memory bytes out MSB first. It does this by pulling the open-drain data line low for every zero bit.

An 8-bit address counter points into a 256-byte register array. That counter persists from one transaction to the next. A read that has no address phase resumes where the previous access stopped. A write-type select followed by one address byte reloads the counter, which a repeated start and a read select can then use for a random read.

After each byte sent, the master's acknowledge on the ninth clock decides the next step. A low level means the engine streams the next byte. A high level means the engine returns to standby. Streaming wraps from address FFh to 00h.

Top module: `i2c_rd_engine`

## Requirements
- R1: After reset, `sda_oe_o` is 0 (data line released) and the address counter is 00h.
- R2: A select byte whose bits [7:4] equal the type identifier (default 1010b), whose bits [3:1] equal `pin_addr_i`, and whose bit 0 is 1 (read) is acknowledged: the engine holds SDA low during the ninth clock.
- R3: After a read select, the engine outputs the byte at the counter, MSB first. At reset, cell `a` holds (37*a + 11) mod 256.
- R4: The counter advances by one after each complete byte sent. It keeps its value across transactions, so a later read without an address phase continues from there.
- R5: When the master drives SDA low on the ninth clock of a read byte, the engine sends the byte at the next consecutive address.
- R6: After address FFh, the counter wraps to 00h and streaming continues from 00h.
- R7: If SDA is high on the ninth clock of a read byte, the engine releases SDA and ignores further clocks until a start.
- R8: A matching select with bit 0 = 0 is acknowledged. The following address byte is acknowledged and loaded into the counter. Any later data byte in that transaction gets no acknowledge.
- R9: A select byte that does not match gets no acknowledge, and the engine keeps SDA released until the next start.
- R10: A repeated start in the middle of a read byte aborts that byte without advancing the counter, and select decoding starts again.
- R11: A stop condition releases SDA and returns the engine to standby.
- R12: The engine begins pulling SDA low only while SCL is low, so SDA stays stable while SCL is high during data and acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| pin_addr_i | input | 3 | Strapped device address pins |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
A wrong counter value shows up at once at the ports: the first data byte of the next read carries the wrong pattern. An increment that is lost or doubled shows up on the second byte of a stream. A control state that fails to reach standby shows up as a pull-down on a bit where the bus should read high: after a missing acknowledge, after a stop, or on a non-matching select. A stale shift register or bit count shifts every byte by one bit position, which the first byte compare exposes.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  // Control states of the read engine
  typedef enum logic [2:0] {
    ST_IDLE,      // standby, bus ignored until start
    ST_SEL,       // shifting in the select byte
    ST_SEL_ACK,   // driving the select acknowledge
    ST_WADR,      // shifting in the word address
    ST_WADR_ACK,  // driving the address acknowledge
    ST_SEND,      // shifting a memory byte out
    ST_MACK       // waiting for the master acknowledge
  } rd_state_e;
endpackage

// File: rtl/i2c_rd_busmon.sv
module i2c_rd_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int k = 1; k < SYNC_STAGES; k++) begin
        scl_pipe[k] <= scl_pipe[k-1];
        sda_pipe[k] <= sda_pipe[k-1];
      end
      scl_prev <= scl_pipe[LAST];
      sda_prev <= sda_pipe[LAST];
    end
  end

  assign scl_lvl_o  = scl_pipe[LAST];
  assign sda_lvl_o  = sda_pipe[LAST];
  assign scl_rise_o = scl_pipe[LAST] & ~scl_prev;
  assign scl_fall_o = ~scl_pipe[LAST] & scl_prev;
  // data edges while the clock stays high mark bus conditions
  assign start_o = scl_pipe[LAST] & scl_prev & sda_prev & ~sda_pipe[LAST];
  assign stop_o  = scl_pipe[LAST] & scl_prev & ~sda_prev & sda_pipe[LAST];
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW  = 8,
  parameter int DW  = 8,
  parameter int MUL = 37,
  parameter int ADD = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // contents are seeded at reset; writes belong to another block
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= DW'(i * MUL + ADD);
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
#(
  parameter logic [3:0] TYPE_ID     = 4'b1010,
  parameter int         PIN_W       = 3,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         MEM_MUL     = 37,
  parameter int         MEM_ADD     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] pin_addr_i,
  output logic             sda_oe_o
);
  localparam int BYTE_W = 8;
  localparam int ID_W   = 4 + PIN_W;       // select bits compared
  localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [BYTE_W-1:0] mem_rd;

  rd_state_e         state_q;
  logic [3:0]        bcnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rw_q, mack_q, drive_q;
  logic [AW-1:0]     addr_q;

  i2c_rd_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_rd_mem #(.AW(AW), .DW(BYTE_W), .MUL(MEM_MUL), .ADD(MEM_ADD)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr_q), .rd_data(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
      addr_q  <= '0;
    end else if (start_ev) begin
      state_q <= ST_SEL;          // also aborts any byte in flight
      bcnt_q  <= '0;
      drive_q <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SEL, ST_WADR: begin
          if (scl_rise) begin
            sh_q   <= {sh_q[BYTE_W-2:0], sda_lvl};
            bcnt_q <= bcnt_q + 4'd1;
          end else if (scl_fall && bcnt_q == BITS_DONE) begin
            if (state_q == ST_SEL) begin
              if (sh_q[BYTE_W-1:1] == ID_W'({TYPE_ID, pin_addr_i})) begin
                rw_q    <= sh_q[0];
                drive_q <= 1'b1;
                state_q <= ST_SEL_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              addr_q  <= sh_q[AW-1:0];
              drive_q <= 1'b1;
              state_q <= ST_WADR_ACK;
            end
          end
        end
        ST_SEL_ACK: begin
          if (scl_fall) begin
            bcnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_SEND;
              sh_q    <= mem_rd;
              drive_q <= ~mem_rd[BYTE_W-1];
            end else begin
              state_q <= ST_WADR;
              drive_q <= 1'b0;
            end
          end
        end
        ST_WADR_ACK: begin
          if (scl_fall) begin
            drive_q <= 1'b0;
            state_q <= ST_IDLE;      // data bytes are another block's job
          end
        end
        ST_SEND: begin
          if (scl_fall) begin
            if (bcnt_q == BITS_DONE - 4'd1) begin
              state_q <= ST_MACK;
              drive_q <= 1'b0;
              addr_q  <= addr_q + 1'b1;
            end else begin
              bcnt_q  <= bcnt_q + 4'd1;
              sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
              drive_q <= ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_SEND;
              bcnt_q  <= '0;
              sh_q    <= mem_rd;
              drive_q <= ~mem_rd[BYTE_W-1];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          drive_q <= 1'b0;
        end
      endcase
    end
  end

  assign sda_oe_o = drive_q;
endmodule

// File: rtl/i2c_rd_chk.sv
module i2c_rd_chk
  import i2c_rd_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          sda_oe,
  input rd_state_e     st,
  input logic [AW-1:0] addr
);
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  p_start_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!sda_oe && st == ST_SEL));

  p_stop_releases_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (!sda_oe && st == ST_IDLE));

  p_pull_on_low_scl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !$past(scl_lvl));

  p_step_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK && $past(st) == ST_SEND) |-> addr == AW'($past(addr) + 1'b1));
endmodule

bind i2c_rd_engine i2c_rd_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe_o), .st(state_q), .addr(addr_q)
);

// File: tb/i2c_rd_engine_tb_top.sv
`timescale 1ns/1ps
module i2c_rd_engine_tb_top;
  localparam logic [2:0] PINS = 3'b011;
  localparam logic [7:0] SEL_RD = {4'b1010, PINS, 1'b1};
  localparam logic [7:0] SEL_WR = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] SEL_BAD = {4'b1010, 3'b001, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  int maddr = 0;            // reference model of the address counter

  always #5 clk = ~clk;     // 100 MHz
  assign sda_line = sda_m & ~sda_oe;

  i2c_rd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .pin_addr_i(PINS), .sda_oe_o(sda_oe)
  );

  function automatic logic [7:0] ref_byte(input int a);
    return 8'(((a % 256) * 37 + 11) % 256);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL period; SDA set while low, sampled twice while high
  task automatic bit_cyc(input logic d, output logic s);
    logic s2;
    scl_m = 1'b0; wait_n(5);
    sda_m = d;    wait_n(5);
    scl_m = 1'b1; wait_n(3);
    s = sda_line; wait_n(5);
    s2 = sda_line; wait_n(2);
    scl_m = 1'b0;
    chk("R12 sda stable while scl high", int'(s2), int'(s));
  endtask

  task automatic start_c();
    wait_n(3);
    if (!scl_m) begin
      sda_m = 1'b1; wait_n(5);
      scl_m = 1'b1; wait_n(5);
    end
    sda_m = 1'b0; wait_n(5);
    scl_m = 1'b0; wait_n(2);
  endtask

  task automatic stop_c();
    wait_n(3);
    sda_m = 1'b0; wait_n(5);
    scl_m = 1'b1; wait_n(5);
    sda_m = 1'b1; wait_n(5);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
    bit_cyc(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_bits(input int n, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < n; i++) begin
      bit_cyc(1'b1, s);
      v = {v[6:0], s};
    end
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    rd_bits(8, v);
    bit_cyc(~give_ack, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] v;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    chk("R1 reset releases sda", int'(sda_oe), 0);

    // current address read from the reset counter value
    start_c();
    wr_byte(SEL_RD, ak); chk("R2 read select acked", int'(ak), 1);
    rd_byte(1'b0, v); chk("R3 first byte at counter 00h", int'(v), int'(ref_byte(maddr)));
    maddr++;
    stop_c();

    // continue without address phase, stream three bytes
    start_c();
    wr_byte(SEL_RD, ak); chk("R2 read select acked", int'(ak), 1);
    rd_byte(1'b1, v); chk("R4 resumes at kept counter", int'(v), int'(ref_byte(maddr))); maddr++;
    rd_byte(1'b1, v); chk("R5 next consecutive byte", int'(v), int'(ref_byte(maddr))); maddr++;
    rd_byte(1'b0, v); chk("R5 next consecutive byte", int'(v), int'(ref_byte(maddr))); maddr++;
    // no acknowledge: further clocks must see a released line
    rd_bits(8, v); chk("R7 standby after nack", int'(v), 8'hFF);
    bit_cyc(1'b1, ak); chk("R7 no ack in standby", int'(ak), 1);
    stop_c();

    // address load, then a write data byte that gets no ack
    start_c();
    wr_byte(SEL_WR, ak); chk("R8 write select acked", int'(ak), 1);
    wr_byte(8'hFE, ak); chk("R8 address byte acked", int'(ak), 1);
    wr_byte(8'h55, ak); chk("R8 data byte not acked", int'(ak), 0);
    stop_c();
    maddr = 8'hFE;

    // random read across the top of the array
    start_c();
    wr_byte(SEL_WR, ak); chk("R8 write select acked", int'(ak), 1);
    wr_byte(8'hFD, ak); chk("R8 address byte acked", int'(ak), 1);
    maddr = 8'hFD;
    start_c();
    wr_byte(SEL_RD, ak); chk("R2 read select after repeated start", int'(ak), 1);
    rd_byte(1'b1, v); chk("R8 byte at loaded address", int'(v), int'(ref_byte(maddr))); maddr++;
    rd_byte(1'b1, v); chk("R5 next byte", int'(v), int'(ref_byte(maddr))); maddr++;
    rd_byte(1'b1, v); chk("R6 top address byte", int'(v), int'(ref_byte(maddr))); maddr = 0;
    rd_byte(1'b0, v); chk("R6 wrap to 00h", int'(v), int'(ref_byte(maddr))); maddr++;
    stop_c();

    // non-matching select
    start_c();
    wr_byte(SEL_BAD, ak); chk("R9 foreign select not acked", int'(ak), 0);
    rd_byte(1'b0, v); chk("R9 line released after mismatch", int'(v), 8'hFF);
    stop_c();

    // repeated start two bits into a byte (counter 01h: 30h, third bit is 1)
    start_c();
    wr_byte(SEL_RD, ak); chk("R2 read select acked", int'(ak), 1);
    rd_bits(2, v); chk("R10 partial bits before abort", int'(v[1:0]), int'(ref_byte(maddr) >> 6));
    start_c();
    wr_byte(SEL_RD, ak); chk("R10 select decoded after abort", int'(ak), 1);
    rd_byte(1'b0, v); chk("R10 aborted byte not counted", int'(v), int'(ref_byte(maddr))); maddr++;
    stop_c();

    // stop one bit into a byte (counter 02h: 55h, second bit is 1)
    start_c();
    wr_byte(SEL_RD, ak); chk("R2 read select acked", int'(ak), 1);
    rd_bits(1, v); chk("R3 msb first", int'(v[0]), int'(ref_byte(maddr) >> 7));
    stop_c();
    chk("R11 stop releases sda", int'(sda_oe), 0);
    rd_bits(8, v); chk("R11 standby after stop", int'(v), 8'hFF);
    start_c();
    wr_byte(SEL_RD, ak); chk("R2 read select acked", int'(ak), 1);
    rd_byte(1'b0, v); chk("R4 counter held over aborted read", int'(v), int'(ref_byte(maddr))); maddr++;
    stop_c();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule